// File: doc/BRIEF.md
# Analog Comparator Control and Status

This block is the digital wrapper around one analog comparator. Software sees one 8-bit control and status register. It turns the comparator on, picks which of two pins feeds the positive input, and picks whether the negative input comes from an external reference pin or from the internal reference voltage. It can also route the comparator's raw result straight to a device pin.

The raw comparator result is asynchronous. It is brought into the CPU clock domain through a two-flop synchronizer and exposed as a read-only status bit. Every transition of the synchronized result, rising or falling, sets a sticky change flag. The flag feeds an interrupt request that is gated by an external interrupt-enable input.

Each time the comparator is switched on, a settling window starts. Its length is derived from the clock frequency and the settling time. During this window the status bit is held at zero and the flag cannot be set. Switching the comparator off clears both status bits at once.

Top module: `acmp_ctl`

## Requirements
- R1: The register reads back as follows: bit 5 is the enable, bit 4 the positive select, bit 3 the negative select, bit 2 the pin output enable, bit 1 the synchronized result and bit 0 the change flag. Every bit resets to 0, and a write loads bits 5:2 on the clock edge of the write.
- R2: `ana_en`, `ana_psel` and `ana_nsel` follow the stored enable and select bits. A positive select of 0 picks input A and 1 picks input B. A negative select of 0 picks the external reference pin and 1 picks the internal reference.
- R3: `pin_out` equals `cmp_raw` combinationally, with no clock involved, whenever both enable and pin output enable are 1. Otherwise it is 0.
- R4: Once the comparator has settled, a value of `cmp_raw` sampled at clock edge k appears in bit 1 after edge k+2.
- R5: Bit 1 is 0 while enable is 0. It also stays 0 for SETTLE_CYC = CLK_MHZ*SETTLE_US cycles after enable is written to 1; the first load of the result happens at the edge after those cycles. Every new 0-to-1 write of enable restarts the window.
- R6: After settling, every rising or falling change of the synchronized result sets bit 0, on the same edge that bit 1 takes the new value. The end of the settling window does not set the flag by itself.
- R7: Writing 0 to bit 0 clears the flag, and writing 1 leaves it unchanged. If a hardware set and a software clear fall on the same edge, the set wins. A write that clears enable clears the flag on that same edge, and the flag stays 0 while enable is 0.
- R8: Bits 7:6 always read 0. Writes to bits 7:6 and to bit 1 have no effect.
- R9: `irq` is 1 exactly when the flag is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| cmp_raw | input | 1 | Asynchronous comparator result from the analog macro |
| irq_en | input | 1 | Interrupt enable from the interrupt controller |
| ana_en | output | 1 | Comparator power/enable to the analog macro |
| ana_psel | output | 1 | Positive input select (0 = input A, 1 = input B) |
| ana_nsel | output | 1 | Negative input select (0 = external reference pin, 1 = internal reference) |
| pin_out | output | 1 | Raw comparator result routed to the device pin |
| irq | output | 1 | Interrupt request |

## Verification
The bench goes after the edge of the settling window. A counter that is off by one would expose the result a cycle early or late. A design that treats the end of the window as a change would raise a spurious flag when the result is already high at enable. It checks that both falling and rising changes set the flag, since a rising-only detector would miss every falling edge of the comparator. It also checks the disable path: a design that cleared the status bits one cycle late, or left the pin driven, would show stale state right after the disabling write. Finally, it checks that writing 1 to the flag or to the result bit changes nothing, while a long pseudo-random result pattern mixed with clearing writes tests set-over-clear priority on coinciding edges.

// File: rtl/acmp_pkg.sv
// Shared field positions and the control-field type for the comparator
// control block. Assumes an 8-bit register with reserved bits at the top.
package acmp_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned POS_EN   = 5;
    localparam int unsigned POS_PSEL = 4;
    localparam int unsigned POS_NSEL = 3;
    localparam int unsigned POS_OE   = 2;
    localparam int unsigned POS_CO   = 1;
    localparam int unsigned POS_FLAG = 0;

    typedef struct packed {
        logic en;
        logic psel;
        logic nsel;
        logic oe;
    } acmp_ctl_t;

    // Extract the writable control fields from a write word.
    function automatic acmp_ctl_t ctl_from_word(input logic [REG_W-1:0] w);
        acmp_ctl_t c;
        c.en   = w[POS_EN];
        c.psel = w[POS_PSEL];
        c.nsel = w[POS_NSEL];
        c.oe   = w[POS_OE];
        return c;
    endfunction

    // Assemble the read word; reserved bits are zero.
    function automatic logic [REG_W-1:0] word_from_state(input acmp_ctl_t c,
                                                         input logic co,
                                                         input logic flag);
        logic [REG_W-1:0] w;
        w           = '0;
        w[POS_EN]   = c.en;
        w[POS_PSEL] = c.psel;
        w[POS_NSEL] = c.nsel;
        w[POS_OE]   = c.oe;
        w[POS_CO]   = co;
        w[POS_FLAG] = flag;
        return w;
    endfunction

endpackage

// File: rtl/acmp_sync.sv
// Multi-flop synchronizer for the asynchronous comparator result.
// Assumes STAGES >= 2. The chain runs every cycle, whether or not the
// comparator is enabled; gating is applied downstream.
module acmp_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Capture the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= d_async;
            end
        end else begin : g_next
            // Shift toward the output to resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/acmp_settle.sv
// Settling-window timer. It counts CYCLES clock edges while the enable
// has been 1, then raises done. It clears at once when the next enable
// value is 0, so every re-enable restarts the window. Assumes CYCLES >= 1.
module acmp_settle #(
    parameter int unsigned CYCLES = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_cur,
    input  logic en_next,
    output logic done
);

    localparam int unsigned CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    // Advance the window counter while enabled and not yet settled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_next) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (en_cur && !done) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) done <= 1'b1;
        end
    end

endmodule

// File: rtl/acmp_status.sv
// Status bits: the gated synchronized result and the sticky change flag.
// Assumes sync_val is already in the clock domain. A change is the
// synchronized value differing from its value one cycle earlier. A
// hardware set takes priority over a software clear on the same edge.
module acmp_status (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_val,
    input  logic en_next,
    input  logic settled,
    input  logic sw_clr,
    output logic co,
    output logic flag
);

    logic prev;
    logic chg;

    assign chg = sync_val ^ prev;

    // Remember the last synchronized value for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sync_val;
    end

    // Expose the result only while enabled and settled.
    always_ff @(posedge clk) begin
        if (!rst_n)                   co <= 1'b0;
        else if (en_next && settled)  co <= sync_val;
        else                          co <= 1'b0;
    end

    // Sticky change flag: disable clears, change sets, software clears.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_next)       flag <= 1'b0;
        else if (settled && chg)      flag <= 1'b1;
        else if (sw_clr)              flag <= 1'b0;
    end

endmodule

// File: rtl/acmp_ctl.sv
// Control and status wrapper for one analog comparator. It holds the
// software register, drives the analog selects, synchronizes the raw
// result, times the settling window, and raises a change interrupt.
// Assumes a single-cycle write strobe and a synchronous active-low reset.
module acmp_ctl #(
    parameter int unsigned CLK_MHZ     = 125,
    parameter int unsigned SETTLE_US   = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr_en,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       cmp_raw,
    input  logic       irq_en,
    output logic       ana_en,
    output logic       ana_psel,
    output logic       ana_nsel,
    output logic       pin_out,
    output logic       irq
);

    import acmp_pkg::*;

    localparam int unsigned SETTLE_CYC = CLK_MHZ * SETTLE_US;

    acmp_ctl_t ctl_q;
    acmp_ctl_t wr_ctl;
    logic      en_next;
    logic      sw_clr;
    logic      sync_val;
    logic      settled;
    logic      co_q;
    logic      flag_q;

    assign wr_ctl  = ctl_from_word(reg_wdata);
    assign en_next = reg_wr_en ? wr_ctl.en : ctl_q.en;
    assign sw_clr  = reg_wr_en && !reg_wdata[POS_FLAG];

    // Load the writable control fields on a register write.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctl_q <= '0;
        else if (reg_wr_en) ctl_q <= wr_ctl;
    end

    acmp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (cmp_raw),
        .q_sync  (sync_val)
    );

    acmp_settle #(.CYCLES(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_cur  (ctl_q.en),
        .en_next (en_next),
        .done    (settled)
    );

    acmp_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_val (sync_val),
        .en_next  (en_next),
        .settled  (settled),
        .sw_clr   (sw_clr),
        .co       (co_q),
        .flag     (flag_q)
    );

    assign reg_rdata = word_from_state(ctl_q, co_q, flag_q);
    assign ana_en    = ctl_q.en;
    assign ana_psel  = ctl_q.psel;
    assign ana_nsel  = ctl_q.nsel;
    assign pin_out   = cmp_raw & ctl_q.en & ctl_q.oe;
    assign irq       = flag_q & irq_en;

endmodule

// File: rtl/acmp_ctl_chk.sv
// Property checker for acmp_ctl, attached by bind. Keeps its own count of
// cycles since enable so that the settling window is checked without deep
// history.
module acmp_ctl_chk #(
    parameter int unsigned CLK_MHZ   = 125,
    parameter int unsigned SETTLE_US = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] reg_rdata,
    input logic       irq_en,
    input logic       ana_en,
    input logic       pin_out,
    input logic       irq
);

    localparam int unsigned WIN = CLK_MHZ * SETTLE_US;

    int unsigned win_cnt;

    // Count cycles the register has shown enable, saturating at WIN.
    always_ff @(posedge clk) begin
        if (!rst_n || !reg_rdata[5]) win_cnt <= 0;
        else if (win_cnt < WIN)      win_cnt <= win_cnt + 1;
    end

    // R8
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[7:6] == 2'b00);

    // R5
    co_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[5] |-> !reg_rdata[1]);

    // R7
    flag_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[5] |-> !reg_rdata[0]);

    // R3
    pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rdata[5] && reg_rdata[2]) |-> !pin_out);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (irq_en && reg_rdata[0]));

    // R5
    settle_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[1] |-> (win_cnt == WIN));

    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_rdata[0]) |-> (reg_rdata[5] && win_cnt == WIN));

    // R2
    en_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ana_en == reg_rdata[5]);

endmodule

bind acmp_ctl acmp_ctl_chk #(
    .CLK_MHZ   (CLK_MHZ),
    .SETTLE_US (SETTLE_US)
) u_acmp_ctl_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rdata (reg_rdata),
    .irq_en    (irq_en),
    .ana_en    (ana_en),
    .pin_out   (pin_out),
    .irq       (irq)
);

// File: tb/test_acmp_ctl.sv
// Bench for acmp_ctl: a behavioural model, updated at every rising edge,
// compared with all outputs at every falling edge, plus directed checks.
module test_acmp_ctl;

    localparam int unsigned CLK_MHZ   = 125;
    localparam int unsigned SETTLE_US = 10;
    localparam int          N         = CLK_MHZ * SETTLE_US;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       cmp_raw = 1'b0;
    logic       irq_en = 1'b0;
    logic       ana_en, ana_psel, ana_nsel, pin_out, irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    acmp_ctl #(.CLK_MHZ(CLK_MHZ), .SETTLE_US(SETTLE_US)) i_acmp_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmp_raw(cmp_raw), .irq_en(irq_en),
        .ana_en(ana_en), .ana_psel(ana_psel), .ana_nsel(ana_nsel),
        .pin_out(pin_out), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model state
    bit m_en, m_psel, m_nsel, m_oe, m_co, m_flag;
    bit hist[$];
    int on_cnt;

    always @(posedge clk) begin
        bit en_n, ready, s2, s3;
        if (!rst_n) begin
            m_en = 0; m_psel = 0; m_nsel = 0; m_oe = 0; m_co = 0; m_flag = 0;
            hist = '{0, 0, 0};
            on_cnt = 0;
        end else begin
            en_n  = reg_wr_en ? reg_wdata[5] : m_en;
            ready = (on_cnt >= N);
            s2 = hist[1];
            s3 = hist[2];
            if (!en_n)                          m_flag = 0;
            else if (ready && (s2 != s3))       m_flag = 1;
            else if (reg_wr_en && !reg_wdata[0]) m_flag = 0;
            m_co = (en_n && ready) ? s2 : 1'b0;
            if (!en_n)     on_cnt = 0;
            else if (m_en) on_cnt++;
            if (reg_wr_en) begin
                m_en = reg_wdata[5]; m_psel = reg_wdata[4];
                m_nsel = reg_wdata[3]; m_oe = reg_wdata[2];
            end
            hist.push_front(cmp_raw);
            void'(hist.pop_back());
        end
    end

    // Compare every output with the model each cycle.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R1 ctl bits", int'(reg_rdata[5:2]), int'({m_en, m_psel, m_nsel, m_oe}));
            check("R2 analog drive", int'({ana_en, ana_psel, ana_nsel}), int'({m_en, m_psel, m_nsel}));
            check("R3 pin", int'(pin_out), int'(cmp_raw & m_en & m_oe));
            check("R4/R5 result bit", int'(reg_rdata[1]), int'(m_co));
            check("R6/R7 flag", int'(reg_rdata[0]), int'(m_flag));
            check("R8 reserved", int'(reg_rdata[7:6]), 0);
            check("R9 irq", int'(irq), int'(m_flag & irq_en));
        end
    end

    task automatic wr(input logic [7:0] v);
        @(posedge clk); #1;
        reg_wr_en = 1'b1; reg_wdata = v;
        @(posedge clk); #1;
        reg_wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        logic [15:0] lfsr;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R1 reset value", int'(reg_rdata), 0);

        wr(8'b0001_1000);
        check("R2 psel=B nsel=internal", int'({ana_en, ana_psel, ana_nsel}), 3);
        wr(8'b0000_1000);
        check("R2 psel=A", int'(ana_psel), 0);

        wr(8'b0000_0100);
        cmp_raw = 1'b1;
        idle(4);
        check("R3 pin low while disabled", int'(pin_out), 0);
        check("R5 result 0 while disabled", int'(reg_rdata[1]), 0);

        wr(8'b0010_0100);
        check("R3 pin follows raw", int'(pin_out), 1);
        idle(100);
        check("R5 result held in window", int'(reg_rdata[1]), 0);
        idle(N);
        check("R4 result after settling", int'(reg_rdata[1]), 1);
        check("R6 settling sets no flag", int'(reg_rdata[0]), 0);

        cmp_raw = 1'b0;
        #1 check("R3 pin async low", int'(pin_out), 0);
        idle(4);
        check("R6 falling change flags", int'(reg_rdata[1:0]), 1);
        irq_en = 1'b0; #1;
        check("R9 irq masked", int'(irq), 0);
        irq_en = 1'b1; #1;
        check("R9 irq raised", int'(irq), 1);

        wr(8'b1110_0111);
        check("R7 write 1 keeps flag", int'(reg_rdata[0]), 1);
        check("R8 result/reserved not writable", int'(reg_rdata[7:6] | {1'b0, reg_rdata[1]}), 0);
        wr(8'b0010_0100);
        check("R7 write 0 clears flag", int'(reg_rdata[0]), 0);
        cmp_raw = 1'b1;
        idle(4);
        check("R6 rising change flags", int'(reg_rdata[1:0]), 3);

        wr(8'b0000_0100);
        check("R7 disable clears both", int'(reg_rdata[1:0]), 0);
        check("R3 pin low after disable", int'(pin_out), 0);
        wr(8'b0010_0100);
        idle(200);
        check("R5 window restarts", int'(reg_rdata[1]), 0);
        idle(N);

        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cmp_raw = (lfsr[3:0] > 4'd9) ? ~cmp_raw : cmp_raw;
            irq_en  = lfsr[7];
            reg_wr_en = (lfsr[11:8] == 4'd0);
            reg_wdata = {7'b0010_010, lfsr[12]};
            @(posedge clk); #1;
        end
        reg_wr_en = 1'b0;
        idle(4);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule